// File: doc/BRIEF.md
# Quad-Data-Rate SRAM DLL Bring-Up Sequencer

This block sits in a memory controller beside a quad-data-rate synchronous SRAM. It takes the memory from power-up to normal operation. It drives the level of the memory's DLL enable pin, where 0 switches the DLL off. It gates the memory's K and C clocks, and a gated clock is held low. While the memory is not ready, it forces the command bus to NOP. It counts the NOP cycles that the memory sees with running clocks. When the required count is reached, it raises a ready level to the controller. An external circuit reports clock stability to the block on an input flag.

A static two-bit input picks one of three bring-up paths:

- **DLL permanently off.** The enable pin stays low, and the block only waits out the NOP period.
- **DLL enabled by the pin.** The pin rises once the clocks are stable, and the NOP lock period starts with that rise.
- **DLL reset by a clock stop.** The pin stays high. The block first stops all memory clocks for a minimum time, then restarts them and counts the NOP lock period.

After ready, the controller can request a clock stop or signal a change of operating frequency. Either request drops ready at once and re-runs the matching recovery sequence.

States:

| State | Meaning |
|---|---|
| `ST_WAIT_CLK` | Waiting for stable clocks |
| `ST_CLK_STOP` | Memory clocks gated low |
| `ST_DLL_RST` | Enable pin pulled low to reset the DLL |
| `ST_NOP_CNT` | Counting NOP cycles |
| `ST_READY` | Normal operation |

Transitions:

| From | To | Condition |
|---|---|---|
| `ST_WAIT_CLK` | `ST_CLK_STOP` | Clock stable, clock-stop mode |
| `ST_WAIT_CLK` | `ST_NOP_CNT` | Clock stable, any other mode |
| `ST_CLK_STOP` | `ST_NOP_CNT` | Stop time elapsed |
| `ST_DLL_RST` | `ST_NOP_CNT` | Stop time elapsed |
| `ST_NOP_CNT` | `ST_READY` | Last NOP cycle reached |
| `ST_READY` | `ST_CLK_STOP` | Stop request, or frequency change in clock-stop mode |
| `ST_READY` | `ST_DLL_RST` | Frequency change in pin mode |
| `ST_READY` | `ST_NOP_CNT` | Frequency change with the DLL off |
| any state | `ST_WAIT_CLK` | Loss of clock stability |

Top module: `qsram_init_seq`

## Requirements
- R1: While synchronous active-high reset is applied, and in the first cycle after it, the block holds `ready` at 0, `dll_en` at 0 and `mem_clk_en` at 1, drives `mem_cmd` to NOP, and sits in the wait-for-stable-clock state.
- R2: With `mode_sel` 00, or the reserved value 11, `dll_en` stays 0 at all times. Once `clk_stable` is 1, exactly NOP_CYC not-ready cycles with running clocks follow, and then `ready` is 1.
- R3: With `mode_sel` 01, `dll_en` is 0 while waiting for stable clocks. It is 1 from the first NOP cycle on, and NOP_CYC not-ready cycles with `dll_en` high come before `ready`.
- R4: With `mode_sel` 10, `dll_en` is 1 from the second cycle after reset on. Once `clk_stable` is 1, the clocks are gated for the stop time and then NOP_CYC NOP cycles follow before `ready`.
- R5: The stop time is STOP_CYC = ceil(STOP_MIN_PS / REF_PERIOD_PS) reference cycles, which is 3 at the defaults. During it, `mem_clk_en` is 0, meaning K and C are held low, and `ready` is 0.
- R6: Command encodings are NOP = 00, READ = 01 and WRITE = 10. While `ready` is 0, `mem_cmd` is NOP whatever `host_cmd` holds. While `ready` is 1, `mem_cmd` equals `host_cmd`.
- R7: A `stop_req` seen while ready drops `ready` in that same cycle. STOP_CYC gated cycles and then NOP_CYC NOP cycles follow, and `dll_en` is unchanged throughout.
- R8: A `freq_req` seen while ready drops `ready` in that same cycle. What follows depends on the mode:
  - in pin mode, STOP_CYC cycles with `dll_en` low, then NOP_CYC NOP cycles with it high;
  - in clock-stop mode, the same sequence as R7;
  - with the DLL off, NOP_CYC NOP cycles only.
- R9: `stop_req` and `freq_req` have no effect while the block is not ready. A bring-up that sees them still takes exactly NOP_CYC NOP cycles, with no stop and no DLL reset.
- R10: When `stop_req` and `freq_req` arrive together, the clock stop is taken and the DLL reset path is not.
- R11: If `clk_stable` falls, `ready` drops in that same cycle and the block returns to waiting. In pin mode `dll_en` goes low on the next cycle. When `clk_stable` returns, a full NOP_CYC count runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Bring-up mode: 00 DLL off, 01 pin-enabled DLL, 10 clock-stop DLL reset, 11 treated as 00 |
| clk_stable | input | 1 | Memory clocks are stable |
| stop_req | input | 1 | Request to stop the memory clocks |
| freq_req | input | 1 | Operating frequency change request |
| host_cmd | input | 2 | Command from the controller |
| mem_cmd | output | 2 | Command driven to the memory |
| dll_en | output | 1 | DLL enable pin level, 0 switches the DLL off |
| mem_clk_en | output | 1 | Memory clock enable, 0 holds K and C low |
| ready | output | 1 | Memory may take reads and writes |

## Verification
The bench counts, per bring-up or recovery, the not-ready cycles, the gated cycles and the cycles with the DLL pin low. An off-by-one in either counter therefore shows up as 1023, 1025, 2 or 4 where 1024 or 3 is expected. It probes `ready` and `mem_cmd` just after raising a request, before any edge, so a design that drops ready one cycle late, or lets one command through, is caught. It also checks three further cases:
- requests poked in the middle of a NOP count, which a design that honours them answers with a longer or gated sequence;
- simultaneous requests in pin mode, where wrong priority shows up as a DLL-low count;
- loss of clock stability while ready, where a design that keeps the pin high or skips the recount is exposed.

// File: rtl/qsi_pkg.sv
package qsi_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_CLK = 3'd0,
        ST_CLK_STOP = 3'd1,
        ST_DLL_RST  = 3'd2,
        ST_NOP_CNT  = 3'd3,
        ST_READY    = 3'd4
    } qsi_state_e;

    localparam logic [1:0] MODE_DLL_OFF  = 2'b00;
    localparam logic [1:0] MODE_PIN      = 2'b01;
    localparam logic [1:0] MODE_CLK_STOP = 2'b10;

    localparam int CMD_W = 2;
    localparam logic [CMD_W-1:0] CMD_NOP   = 2'b00;
    localparam logic [CMD_W-1:0] CMD_READ  = 2'b01;
    localparam logic [CMD_W-1:0] CMD_WRITE = 2'b10;

endpackage

// File: rtl/qsi_cycle_counter.sv
module qsi_cycle_counter #(
    parameter int STOP_CYC = 3,
    parameter int NOP_CYC  = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic hit_stop,
    output logic hit_nop
);
    localparam int MAX_CYC = (NOP_CYC > STOP_CYC) ? NOP_CYC : STOP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != CNT_W'(MAX_CYC))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_stop = (cnt_q == CNT_W'(STOP_CYC - 1));
    assign hit_nop  = (cnt_q == CNT_W'(NOP_CYC - 1));

endmodule

// File: rtl/qsi_seq_fsm.sv
module qsi_seq_fsm
    import qsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       clk_stable,
    input  logic       stop_req,
    input  logic       freq_req,
    input  logic       hit_stop,
    input  logic       hit_nop,
    output logic       cnt_clr,
    output logic       cnt_en,
    output logic       dll_en_q,
    output logic       clk_en_q,
    output logic       rdy_q
);
    qsi_state_e state_q, state_d;

    function automatic logic pin_level(qsi_state_e s, logic [1:0] m);
        logic lvl;
        if (m == MODE_CLK_STOP) begin
            lvl = 1'b1;
        end else if (m == MODE_PIN) begin
            lvl = (s != ST_WAIT_CLK) && (s != ST_DLL_RST);
        end else begin
            lvl = 1'b0;
        end
        return lvl;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_CLK;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!clk_stable) begin
            state_d = ST_WAIT_CLK;
        end else begin
            unique case (state_q)
                ST_WAIT_CLK: begin
                    if (mode_sel == MODE_CLK_STOP) begin
                        state_d = ST_CLK_STOP;
                    end else begin
                        state_d = ST_NOP_CNT;
                    end
                end
                ST_CLK_STOP: if (hit_stop) state_d = ST_NOP_CNT;
                ST_DLL_RST:  if (hit_stop) state_d = ST_NOP_CNT;
                ST_NOP_CNT:  if (hit_nop)  state_d = ST_READY;
                ST_READY: begin
                    if (stop_req) begin
                        state_d = ST_CLK_STOP;
                    end else if (freq_req) begin
                        if (mode_sel == MODE_PIN) begin
                            state_d = ST_DLL_RST;
                        end else if (mode_sel == MODE_CLK_STOP) begin
                            state_d = ST_CLK_STOP;
                        end else begin
                            state_d = ST_NOP_CNT;
                        end
                    end
                end
                default: state_d = ST_WAIT_CLK;
            endcase
        end
    end

    assign cnt_clr = (state_d != state_q);
    assign cnt_en  = (state_q == ST_CLK_STOP) || (state_q == ST_DLL_RST)
                   || (state_q == ST_NOP_CNT);

    // outputs, registered from the next state so pins change with the state
    always_ff @(posedge clk) begin
        if (rst) begin
            dll_en_q <= 1'b0;
            clk_en_q <= 1'b1;
            rdy_q    <= 1'b0;
        end else begin
            dll_en_q <= pin_level(state_d, mode_sel);
            clk_en_q <= (state_d != ST_CLK_STOP);
            rdy_q    <= (state_d == ST_READY);
        end
    end

endmodule

// File: rtl/qsi_cmd_gate.sv
module qsi_cmd_gate
    import qsi_pkg::*;
(
    input  logic             rdy_q,
    input  logic             clk_stable,
    input  logic             stop_req,
    input  logic             freq_req,
    input  logic [CMD_W-1:0] host_cmd,
    output logic             ready,
    output logic [CMD_W-1:0] mem_cmd
);
    always_comb begin
        ready   = rdy_q && clk_stable && !stop_req && !freq_req;
        mem_cmd = ready ? host_cmd : CMD_NOP;
    end

endmodule

// File: rtl/qsram_init_seq.sv
module qsram_init_seq
    import qsi_pkg::*;
#(
    parameter int REF_PERIOD_PS = 10000,
    parameter int STOP_MIN_PS   = 30000,
    parameter int NOP_CYC       = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       clk_stable,
    input  logic       stop_req,
    input  logic       freq_req,
    input  logic [1:0] host_cmd,
    output logic [1:0] mem_cmd,
    output logic       dll_en,
    output logic       mem_clk_en,
    output logic       ready
);
    localparam int STOP_RAW = (STOP_MIN_PS + REF_PERIOD_PS - 1) / REF_PERIOD_PS;
    localparam int STOP_CYC = (STOP_RAW < 1) ? 1 : STOP_RAW;

    logic cnt_clr, cnt_en, hit_stop, hit_nop;
    logic dll_en_q, clk_en_q, rdy_q;

    qsi_cycle_counter #(
        .STOP_CYC(STOP_CYC),
        .NOP_CYC (NOP_CYC)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .en      (cnt_en),
        .hit_stop(hit_stop),
        .hit_nop (hit_nop)
    );

    qsi_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .clk_stable(clk_stable),
        .stop_req  (stop_req),
        .freq_req  (freq_req),
        .hit_stop  (hit_stop),
        .hit_nop   (hit_nop),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en),
        .dll_en_q  (dll_en_q),
        .clk_en_q  (clk_en_q),
        .rdy_q     (rdy_q)
    );

    qsi_cmd_gate u_gate (
        .rdy_q     (rdy_q),
        .clk_stable(clk_stable),
        .stop_req  (stop_req),
        .freq_req  (freq_req),
        .host_cmd  (host_cmd),
        .ready     (ready),
        .mem_cmd   (mem_cmd)
    );

    assign dll_en     = dll_en_q;
    assign mem_clk_en = clk_en_q;

endmodule

// File: rtl/qsi_checker.sv
module qsi_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       clk_stable,
    input logic       stop_req,
    input logic       freq_req,
    input logic [1:0] mem_cmd,
    input logic       dll_en,
    input logic       mem_clk_en,
    input logic       ready
);
    a_r6_idle_cmd_nop: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (mem_cmd == 2'b00));

    a_r2_pin_low_dll_off: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00) |-> !dll_en);

    a_r4_pin_high_clk_stop: assert property (@(posedge clk) disable iff (rst)
        ((mode_sel == 2'b10) && !$past(rst)) |-> dll_en);

    a_r5_gated_not_ready: assert property (@(posedge clk) disable iff (rst)
        !mem_clk_en |-> !ready);

    a_r5_restart_not_ready: assert property (@(posedge clk) disable iff (rst)
        !mem_clk_en |=> !ready);

    a_r7_req_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (stop_req || freq_req) |-> !ready);

    a_r11_unstable_not_ready: assert property (@(posedge clk) disable iff (rst)
        !clk_stable |-> !ready);

    a_r3_pin_rise_not_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(dll_en) |-> !ready);

endmodule

bind qsram_init_seq qsi_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .clk_stable(clk_stable),
    .stop_req  (stop_req),
    .freq_req  (freq_req),
    .mem_cmd   (mem_cmd),
    .dll_en    (dll_en),
    .mem_clk_en(mem_clk_en),
    .ready     (ready)
);

// File: tb/qsram_init_seq_test.sv
module qsram_init_seq_test;

    localparam int NOP = 1024;
    localparam int STP = 3;     // ceil(30000 ps / 10000 ps)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       clk_stable = 1'b0;
    logic       stop_req = 1'b0;
    logic       freq_req = 1'b0;
    logic [1:0] host_cmd = 2'b10;
    logic [1:0] mem_cmd;
    logic       dll_en, mem_clk_en, ready;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    qsram_init_seq uut (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .clk_stable(clk_stable),
        .stop_req  (stop_req),
        .freq_req  (freq_req),
        .host_cmd  (host_cmd),
        .mem_cmd   (mem_cmd),
        .dll_en    (dll_en),
        .mem_clk_en(mem_clk_en),
        .ready     (ready)
    );

    // vector: {mode[31:30], wait_pin[29], total[27:16], stop[15:12], low[11:0]}
    localparam logic [31:0] VEC [4] = '{
        {2'b00, 1'b0, 1'b0, 12'(NOP),       4'(0),   12'(NOP)},
        {2'b01, 1'b0, 1'b0, 12'(NOP),       4'(0),   12'(0)},
        {2'b10, 1'b1, 1'b0, 12'(NOP + STP), 4'(STP), 12'(0)},
        {2'b11, 1'b0, 1'b0, 12'(NOP),       4'(0),   12'(NOP)}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts not-ready samples until ready; optionally pokes requests mid-count
    task automatic run_to_ready(input int poke, output int tot, output int stp,
                                output int low, output int bad);
        tot = 0; stp = 0; low = 0; bad = 0;
        for (int k = 0; k < 6000; k++) begin
            @(posedge clk);
            @(negedge clk);
            stop_req = 1'b0;
            freq_req = 1'b0;
            if (ready) break;
            tot++;
            if (!mem_clk_en) stp++;
            if (!dll_en) low++;
            if (mem_cmd != 2'b00) bad++;
            if (poke > 0 && k == poke) begin
                stop_req = 1'b1;
                freq_req = 1'b1;
            end
        end
    endtask

    task automatic bring_up(input logic [1:0] m);
        rst = 1'b1;
        mode_sel = m;
        clk_stable = 1'b0;
        stop_req = 1'b0;
        freq_req = 1'b0;
        host_cmd = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int tot, stp, low, bad;

        // R1: reset state
        clk_stable = 1'b1;
        host_cmd = 2'b10;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
        check(dll_en == 1'b0, "R1 dll_en in reset", int'(dll_en), 0);
        check(mem_clk_en == 1'b1, "R1 clk enable in reset", int'(mem_clk_en), 1);
        check(mem_cmd == 2'b00, "R1 cmd NOP in reset", int'(mem_cmd), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b0 && dll_en == 1'b0, "R1 first cycle after reset",
              int'({ready, dll_en}), 0);

        // table of bring-ups per mode (R2, R3, R4, R5, R6)
        for (int v = 0; v < 4; v++) begin
            bring_up(VEC[v][31:30]);
            check(dll_en == VEC[v][29], "R2 R3 R4 pin while waiting",
                  int'(dll_en), int'(VEC[v][29]));
            check(ready == 1'b0, "R2 not ready while waiting", int'(ready), 0);
            clk_stable = 1'b1;
            run_to_ready(0, tot, stp, low, bad);
            check(tot == int'(VEC[v][27:16]), "R2 R3 R4 not-ready cycles",
                  tot, int'(VEC[v][27:16]));
            check(stp == int'(VEC[v][15:12]), "R5 gated cycles", stp, int'(VEC[v][15:12]));
            check(low == int'(VEC[v][11:0]), "R2 R3 dll low cycles", low, int'(VEC[v][11:0]));
            check(bad == 0, "R6 non-NOP while not ready", bad, 0);
            check(ready == 1'b1, "R2 ready after count", int'(ready), 1);
            check(mem_cmd == 2'b10, "R6 write passes", int'(mem_cmd), 2);
            host_cmd = 2'b01;
            #1;
            check(mem_cmd == 2'b01, "R6 read passes", int'(mem_cmd), 1);
        end

        // R8: frequency change, pin mode
        bring_up(2'b01);
        clk_stable = 1'b1;
        run_to_ready(0, tot, stp, low, bad);
        freq_req = 1'b1;
        #1;
        check(ready == 1'b0, "R8 ready drops same cycle", int'(ready), 0);
        check(mem_cmd == 2'b00, "R6 cmd NOP on request", int'(mem_cmd), 0);
        run_to_ready(0, tot, stp, low, bad);
        check(low == STP, "R8 pin mode dll reset cycles", low, STP);
        check(stp == 0, "R8 pin mode no clock stop", stp, 0);
        check(tot == NOP + STP, "R8 pin mode total", tot, NOP + STP);

        // R7: clock stop request, pin mode keeps pin high
        stop_req = 1'b1;
        #1;
        check(ready == 1'b0, "R7 ready drops same cycle", int'(ready), 0);
        run_to_ready(0, tot, stp, low, bad);
        check(stp == STP, "R7 gated cycles", stp, STP);
        check(low == 0, "R7 pin unchanged", low, 0);
        check(tot == NOP + STP, "R7 total", tot, NOP + STP);

        // R10: both requests together take the clock stop
        stop_req = 1'b1;
        freq_req = 1'b1;
        run_to_ready(0, tot, stp, low, bad);
        check(stp == STP, "R10 clock stop taken", stp, STP);
        check(low == 0, "R10 no dll reset", low, 0);

        // R11: loss of clock stability
        clk_stable = 1'b0;
        #1;
        check(ready == 1'b0, "R11 ready drops same cycle", int'(ready), 0);
        @(negedge clk);
        check(dll_en == 1'b0, "R11 pin low after loss", int'(dll_en), 0);
        @(negedge clk);
        clk_stable = 1'b1;
        run_to_ready(0, tot, stp, low, bad);
        check(tot == NOP, "R11 full recount", tot, NOP);

        // R8: frequency change, clock-stop mode
        bring_up(2'b10);
        clk_stable = 1'b1;
        run_to_ready(0, tot, stp, low, bad);
        freq_req = 1'b1;
        run_to_ready(0, tot, stp, low, bad);
        check(stp == STP && low == 0, "R8 clock-stop mode gating", stp, STP);
        check(tot == NOP + STP, "R8 clock-stop mode total", tot, NOP + STP);

        // R8: frequency change, DLL off
        bring_up(2'b00);
        clk_stable = 1'b1;
        run_to_ready(0, tot, stp, low, bad);
        freq_req = 1'b1;
        run_to_ready(0, tot, stp, low, bad);
        check(tot == NOP && stp == 0, "R8 dll-off mode nop only", tot, NOP);

        // R9: requests during a count are ignored
        bring_up(2'b01);
        clk_stable = 1'b1;
        run_to_ready(100, tot, stp, low, bad);
        check(tot == NOP, "R9 count unchanged", tot, NOP);
        check(stp == 0 && low == 0, "R9 no stop or reset", stp + low, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule